// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Detector

This block turns a reference clock into a comparison strobe by dividing its rising edges by R+1. It then compares each comparison strobe against the rising edges of a main-divider feedback signal, and drives two active-low correction pulses. The up pulse means the reference was early and the loop must speed up. The down pulse means the feedback was early and the loop must slow down. Each pulse lasts as long as the gap between the two edges, plus one cycle. Both pulses return high together, one cycle after both edges have been seen.

All activity is sampled in one fast system clock domain, and both `ref_in` and `fp_in` are treated as synchronous levels in that domain. `lock_raw` goes high whenever either correction pulse is active. A digital qualifier stands in for an external integrating capacitor. It reports a stable lock once sixteen comparison periods in a row have passed with no pulse wider than a programmable limit. Monitor copies of the comparison strobe and the feedback edge can be silenced without affecting the detector.

Top module: `refpfd_top`

## Requirements
- R1: The divider counts rising edges of `ref_in`, starting from zero after reset. On every (R+1)-th edge, `fc_mon` is high for exactly one clock, in the cycle after the clock edge that samples that rising edge.
- R2: With R equal to 0, every rising edge of `ref_in` produces an `fc_mon` pulse.
- R3: While `direct_mode` is 1, bits 5 and 4 of `r_val` are ignored, so the divide ratio is (r_val[3:0])+1.
- R4: When the comparison strobe comes k clocks before the feedback strobe (k ≥ 1), `up_n` is low for k+1 consecutive clocks and `dn_n` is low for 1 clock. After that, both stay high until the next edge.
- R5: When the feedback strobe comes k clocks before the comparison strobe (k ≥ 1), `dn_n` is low for k+1 clocks and `up_n` is low for 1 clock.
- R6: When both rising edges are sampled on the same clock edge, `up_n` and `dn_n` are each low for exactly one clock.
- R7: `lock_raw` is the NAND of `up_n` and `dn_n`, so it is 1 exactly in the clocks where either pulse output is low.
- R8: Each rising edge of `fp_in` gives a one-clock high pulse on `fp_mon`, in the cycle after the clock edge that samples it.
- R9: While `mon_off` is 1, `fc_mon` and `fp_mon` stay 0, and `up_n` and `dn_n` behave exactly as they do with the monitors on.
- R10: `locked` becomes 1 on the 16th consecutive comparison strobe with no violation. A violation is `lock_raw` staying high for more than `max_width` clocks in a row; a width equal to `max_width` is allowed. After only 15 such strobes, `locked` is still 0.
- R11: A violation clears `locked` and restarts the count of good periods from zero.
- R12: After reset, `up_n` and `dn_n` are 1, and `lock_raw`, `locked`, `fc_mon` and `fp_mon` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal, sampled on clk |
| fp_in | input | 1 | Main-divider feedback signal, sampled on clk |
| r_val | input | 6 | Reference divide value R (ratio R+1) |
| direct_mode | input | 1 | Forces R bits 5:4 to zero |
| mon_off | input | 1 | Silences the fc_mon and fp_mon outputs |
| max_width | input | 4 | Widest allowed pulse in clocks for lock qualification |
| fc_mon | output | 1 | Comparison strobe monitor |
| fp_mon | output | 1 | Feedback edge monitor |
| up_n | output | 1 | Active-low speed-up pulse |
| dn_n | output | 1 | Active-low slow-down pulse |
| lock_raw | output | 1 | NAND of up_n and dn_n |
| locked | output | 1 | Qualified lock flag |

## Verification
The hardest state to reach from the ports is the lock boundary. It needs sixteen error-free comparison periods in a row, and pulse widths that sit exactly at `max_width` or one clock above it. The stimulus drives a periodic reference and feedback pair at a chosen fixed offset. It checks the flag after fifteen and after sixteen periods, then moves the offset up by one clock so that the pulse is one clock too wide. The edge-order cases use randomly drawn offsets in both directions, together with the coincident case.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;
    localparam int unsigned DEF_R_W        = 6;
    localparam int unsigned DEF_DIRECT_W   = 4;
    localparam int unsigned DEF_WIDTH_W    = 4;
    localparam int unsigned DEF_LOCK_COUNT = 16;

    // Rising-edge detect on a sampled level
    function automatic logic rise_of(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction
endpackage

// File: rtl/refpfd_refdiv.sv
module refpfd_refdiv
    import refpfd_pkg::*;
#(
    parameter int unsigned R_W      = DEF_R_W,
    parameter int unsigned DIRECT_W = DEF_DIRECT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_in,
    input  logic [R_W-1:0] r_val,
    input  logic           direct_mode,
    output logic           fc_stb
);
    localparam int unsigned DIRECT_MAX = (1 << DIRECT_W) - 1;

    typedef struct packed {
        logic           ref_q;
        logic [R_W-1:0] cnt;
        logic           fc;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [R_W-1:0] r_eff;
    logic           ref_rise;

    always_comb begin
        r_eff = r_val;
        if (direct_mode) begin
            for (int b = DIRECT_W; b < R_W; b++) r_eff[b] = 1'b0;
        end
        ref_rise  = rise_of(ref_in, st_q.ref_q);
        st_d      = st_q;
        st_d.ref_q = ref_in;
        st_d.fc   = 1'b0;
        if (ref_rise) begin
            if (st_q.cnt >= r_eff) begin
                st_d.cnt = '0;
                st_d.fc  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fc_stb = st_q.fc;

    // strobe is never two clocks wide (R1, R2)
    p_fc_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fc |=> !st_q.fc);

    // count stays inside the direct-mode range once there (R3)
    p_direct_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode && $past(direct_mode) && ($past(st_q.cnt) <= R_W'(DIRECT_MAX)))
        |-> (st_q.cnt <= R_W'(DIRECT_MAX)));
endmodule

// File: rtl/refpfd_detector.sv
module refpfd_detector
    import refpfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fc_stb,
    input  logic fp_in,
    output logic fp_stb,
    output logic up_n,
    output logic dn_n
);
    typedef struct packed {
        logic fp_q;
        logic fp_stb;
        logic up;
        logic dn;
    } pfd_st_t;

    pfd_st_t st_d, st_q;
    logic    clr;

    always_comb begin
        clr         = st_q.up & st_q.dn;
        st_d        = st_q;
        st_d.fp_q   = fp_in;
        st_d.fp_stb = rise_of(fp_in, st_q.fp_q);
        st_d.up     = (st_q.up & ~clr) | fc_stb;
        st_d.dn     = (st_q.dn & ~clr) | st_q.fp_stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fp_stb = st_q.fp_stb;
    assign up_n   = ~st_q.up;
    assign dn_n   = ~st_q.dn;

    // both pulses active never lasts beyond one clock (R4, R5, R6)
    p_joint_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && !dn_n) |=> !(!up_n && !dn_n));

    // a lone down pulse holds until a comparison strobe arrives (R5)
    p_dn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_n && up_n && !fc_stb) |=> !dn_n);

    // a lone up pulse holds until a feedback strobe arrives (R4)
    p_up_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && dn_n && !st_q.fp_stb) |=> !up_n);
endmodule

// File: rtl/refpfd_lockq.sv
module refpfd_lockq
    import refpfd_pkg::*;
#(
    parameter int unsigned WIDTH_W    = DEF_WIDTH_W,
    parameter int unsigned LOCK_COUNT = DEF_LOCK_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fc_stb,
    input  logic               lock_raw,
    input  logic [WIDTH_W-1:0] max_width,
    output logic               locked
);
    localparam int unsigned GC_W   = $clog2(LOCK_COUNT + 1);
    localparam logic [WIDTH_W-1:0] W_MAX = '1;

    typedef struct packed {
        logic [WIDTH_W-1:0] wcnt;
        logic [GC_W-1:0]    good;
        logic               locked;
    } lq_st_t;

    lq_st_t st_d, st_q;
    logic   over;

    always_comb begin
        over = lock_raw && (st_q.wcnt >= max_width);
        st_d = st_q;
        if (!lock_raw)                st_d.wcnt = '0;
        else if (st_q.wcnt != W_MAX)  st_d.wcnt = st_q.wcnt + 1'b1;
        if (over) begin
            st_d.good   = '0;
            st_d.locked = 1'b0;
        end else if (fc_stb) begin
            if (st_q.good != GC_W'(LOCK_COUNT)) st_d.good = st_q.good + 1'b1;
            if (st_q.good >= GC_W'(LOCK_COUNT - 1)) st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;

    // lock is only gained on a comparison strobe (R10)
    p_lock_on_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(fc_stb));

    // an over-wide pulse removes lock next clock (R11)
    p_lock_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> !st_q.locked);
endmodule

// File: rtl/refpfd_top.sv
module refpfd_top
    import refpfd_pkg::*;
#(
    parameter int unsigned R_W        = DEF_R_W,
    parameter int unsigned DIRECT_W   = DEF_DIRECT_W,
    parameter int unsigned WIDTH_W    = DEF_WIDTH_W,
    parameter int unsigned LOCK_COUNT = DEF_LOCK_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_in,
    input  logic               fp_in,
    input  logic [R_W-1:0]     r_val,
    input  logic               direct_mode,
    input  logic               mon_off,
    input  logic [WIDTH_W-1:0] max_width,
    output logic               fc_mon,
    output logic               fp_mon,
    output logic               up_n,
    output logic               dn_n,
    output logic               lock_raw,
    output logic               locked
);
    logic fc_stb;
    logic fp_stb;

    refpfd_refdiv #(.R_W(R_W), .DIRECT_W(DIRECT_W)) refdiv_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .r_val(r_val),
        .direct_mode(direct_mode), .fc_stb(fc_stb)
    );

    refpfd_detector detector_i (
        .clk(clk), .rst_n(rst_n), .fc_stb(fc_stb), .fp_in(fp_in),
        .fp_stb(fp_stb), .up_n(up_n), .dn_n(dn_n)
    );

    assign lock_raw = ~(up_n & dn_n);

    refpfd_lockq #(.WIDTH_W(WIDTH_W), .LOCK_COUNT(LOCK_COUNT)) lockq_i (
        .clk(clk), .rst_n(rst_n), .fc_stb(fc_stb), .lock_raw(lock_raw),
        .max_width(max_width), .locked(locked)
    );

    assign fc_mon = fc_stb & ~mon_off;
    assign fp_mon = fp_stb & ~mon_off;

    // silenced monitors stay low (R9)
    p_mon_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mon_off |-> (!fc_mon && !fp_mon));
endmodule

// File: tb/refpfd_top_tb_top.sv
module refpfd_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fp_in = 1'b0;
    logic [5:0] r_val = '0;
    logic       direct_mode = 1'b0;
    logic       mon_off = 1'b0;
    logic [3:0] max_width = 4'd3;
    logic fc_mon, fp_mon, up_n, dn_n, lock_raw, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int n_up = 0, n_dn = 0, n_raw = 0, n_fc = 0, n_fp = 0, n_rawbad = 0;

    always #2 clk = ~clk;

    refpfd_top dut_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fp_in(fp_in),
        .r_val(r_val), .direct_mode(direct_mode), .mon_off(mon_off),
        .max_width(max_width), .fc_mon(fc_mon), .fp_mon(fp_mon),
        .up_n(up_n), .dn_n(dn_n), .lock_raw(lock_raw), .locked(locked)
    );

    // sample one time unit after each active edge
    always @(posedge clk) begin
        #1;
        if (!up_n) n_up++;
        if (!dn_n) n_dn++;
        if (lock_raw) n_raw++;
        if (fc_mon) n_fc++;
        if (fp_mon) n_fp++;
        if (lock_raw != !(up_n && dn_n)) n_rawbad++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_div(input int pulses, input int r, input bit dir);
        int eff = dir ? (r & 15) : r;
        return pulses / (eff + 1);
    endfunction
    function automatic int exp_up(input int k); return (k >= 0) ? k + 1 : 1;  endfunction
    function automatic int exp_dn(input int k); return (k <= 0) ? 1 - k : 1;  endfunction

    task automatic do_reset();
        ref_in = 1'b0; fp_in = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic ref_train(input int pulses);
        for (int i = 0; i < pulses * 4 + 4; i++) begin
            @(negedge clk);
            ref_in = (i < pulses * 4) && ((i % 4) < 2);
        end
    endtask

    // k >= 0: reference edge first by k clocks; k < 0: feedback first
    task automatic edge_pair(input int k);
        int a = (k >= 0) ? 0 : -k;
        int b = (k >= 0) ? k : 0;
        int span = ((k >= 0) ? k : -k) + 10;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            ref_in = (i >= a) && (i < a + 2);
            fp_in  = (i >= b) && (i < b + 2);
        end
    endtask

    task automatic pair_check(input int k, input string tag);
        int u0 = n_up, d0 = n_dn, r0 = n_raw;
        edge_pair(k);
        chk({tag, " up_n low clocks"}, n_up - u0, exp_up(k));
        chk({tag, " dn_n low clocks"}, n_dn - d0, exp_dn(k));
        chk("R7 lock_raw high clocks", n_raw - r0, (k == 0) ? 1 : exp_up(k) + exp_dn(k) - 1);
    endtask

    task automatic periods(input int n, input int k);
        for (int p = 0; p < n; p++) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                ref_in = (i < 2);
                fp_in  = (i >= k) && (i < k + 2);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0, f0, r;
        void'($urandom(32'd20240611));
        do_reset();
        // R12 reset state
        chk("R12 up_n", up_n, 1);
        chk("R12 dn_n", dn_n, 1);
        chk("R12 lock_raw", lock_raw, 0);
        chk("R12 locked", locked, 0);
        chk("R12 fc_mon", fc_mon, 0);
        chk("R12 fp_mon", fp_mon, 0);

        // R2 pass-through
        r_val = 6'd0; c0 = n_fc; ref_train(7);
        chk("R2 fc pulses at R=0", n_fc - c0, 7);

        // R1 directed top value and random values
        do_reset(); r_val = 6'd63; c0 = n_fc; ref_train(130);
        chk("R1 fc pulses at R=63", n_fc - c0, exp_div(130, 63, 0));
        for (int t = 0; t < 6; t++) begin
            r = $urandom_range(1, 20);
            do_reset(); r_val = 6'(r); c0 = n_fc; ref_train(45);
            chk("R1 fc pulses random R", n_fc - c0, exp_div(45, r, 0));
        end

        // R3 direct mode ignores R[5:4]
        do_reset(); direct_mode = 1'b1; r_val = 6'h35; c0 = n_fc; ref_train(40);
        chk("R3 direct-mode ratio", n_fc - c0, exp_div(40, 6'h35, 1));
        do_reset(); r_val = 6'h30; c0 = n_fc; ref_train(9);
        chk("R3 direct-mode R=0x30 acts as 0", n_fc - c0, 9);
        direct_mode = 1'b0; r_val = 6'd0;

        // R4 R5 R6 R7 R8 detector ordering
        do_reset();
        f0 = n_fp;
        pair_check(3, "R4");
        pair_check(-4, "R5");
        pair_check(0, "R6");
        chk("R8 fp_mon pulses", n_fp - f0, 3);
        for (int t = 0; t < 8; t++) begin
            int k = int'($urandom_range(0, 12)) - 6;
            if (k >= 0) pair_check(k, "R4"); else pair_check(k, "R5");
        end
        chk("R7 lock_raw vs pulse outputs mismatches", n_rawbad, 0);

        // R9 monitors off, detector unchanged
        mon_off = 1'b1; c0 = n_fc; f0 = n_fp;
        pair_check(2, "R9");
        chk("R9 fc_mon silent", n_fc - c0, 0);
        chk("R9 fp_mon silent", n_fp - f0, 0);
        mon_off = 1'b0;

        // R10 lock boundary: width 3 == max_width allowed
        do_reset(); max_width = 4'd3;
        periods(15, 2);
        chk("R10 locked after 15 periods", locked, 0);
        periods(1, 2);
        chk("R10 locked after 16 periods", locked, 1);
        periods(4, 2);
        chk("R10 lock held at width equal to limit", locked, 1);

        // R11 width 4 > limit clears and restarts count
        periods(1, 3);
        chk("R11 lock dropped on wide pulse", locked, 0);
        periods(15, 1);
        chk("R11 count restarted, 15 periods", locked, 0);
        periods(1, 1);
        chk("R11 relock after 16 periods", locked, 1);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule